// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Result Pair

This block holds a pair of result registers, HI and LO, which together form one double-width accumulator. It runs the multiply, divide and move operations of a simple integer core. The core issues an operation by raising `start` for one cycle, with a function code and the two source operands `rsVal` and `rtVal`. The block accepts the request only while it is not busy. Multiplies finish after a fixed short latency. Divides iterate one quotient bit per cycle and then apply a sign-correction cycle.

Divides never trap. Division by zero and the one signed overflow case each give a fixed result. Move operations copy a source operand into HI or LO, or return HI or LO on a read port. That port carries a write-enable, which stays low when the destination index is zero.

Top module: `muldiv_unit`

## Requirements
- R1: Code 24 takes the signed product of rsVal and rtVal, and code 25 the unsigned product. The upper half of the double-width product goes to HI and the lower half to LO.
- R2: Codes 28 (signed) and 29 (unsigned) add the product to the pair {HI,LO}, with the carry out of LO propagating into HI.
- R3: Codes 46 (signed) and 47 (unsigned) subtract the product from {HI,LO}, with the borrow out of LO propagating into HI.
- R4: Code 26 is a signed divide and code 27 an unsigned divide of rsVal by rtVal. The quotient goes to LO and the remainder to HI. A signed quotient truncates toward zero, and the signed remainder takes the sign of the dividend.
- R5: A signed divide by zero sets HI to the dividend. It sets LO to all ones when the dividend is non-negative, and to 1 when the dividend is negative.
- R6: An unsigned divide by zero sets HI to the dividend. It sets LO to all ones when the dividend is greater than 0x0000FFFF, and to 0x0000FFFF otherwise.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF sets LO to 0x80000000 and HI to 0xFFFFFFFF.
- R8: Code 17 writes rsVal into HI and code 19 writes rsVal into LO. Code 16 returns HI and code 18 returns LO on moveData. Every move is visible in the cycle after acceptance, together with `done`.
- R9: moveWe is high for one cycle after an accepted read of HI or LO (code 16 or 18), and only when rdIdx is non-zero.
- R10: After acceptance, a multiply keeps busy high and raises done MUL_LAT+1 cycles later. A divide raises done DATA_W+2 cycles later. done is a one-cycle pulse, seen with busy low and with HI and LO already updated.
- R11: A start while busy is high has no effect. A start with a code outside the list above has no effect: no done, and HI and LO keep their values. HI and LO change only through an accepted operation.
- R12: After reset, HI and LO are zero and busy, done and moveWe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request, sampled when not busy |
| func | input | 6 | Function code of the requested operation |
| rsVal | input | DATA_W | First operand (dividend, multiplicand, move source) |
| rtVal | input | DATA_W | Second operand (divisor, multiplier) |
| rdIdx | input | REG_IDX_W | Destination register index for reads of HI or LO |
| busy | output | 1 | High while a multiply or divide is in flight |
| done | output | 1 | One-cycle completion pulse |
| hiOut | output | DATA_W | Current HI value |
| loOut | output | DATA_W | Current LO value |
| moveData | output | DATA_W | HI or LO value returned by a read |
| moveWe | output | 1 | Register write enable for moveData |

## Verification
Two events can land in the same cycle. The first is a new start arriving while a divide or multiply is still running. The bench provokes it by issuing a move-to-HI in the middle of a divide, then checking that the divide's result is intact and that its latency is unchanged. The second is the cycle in which done is high, which is also the first cycle a new request can be accepted. Every operation in the random stream is issued on the exact cycle the previous done is seen, and the bench compares each result and latency against its own reference model.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [5:0] {
    FN_MFHI = 6'd16,
    FN_MTHI = 6'd17,
    FN_MFLO = 6'd18,
    FN_MTLO = 6'd19,
    FN_MULS = 6'd24,
    FN_MULU = 6'd25,
    FN_DIVS = 6'd26,
    FN_DIVU = 6'd27,
    FN_MACS = 6'd28,
    FN_MACU = 6'd29,
    FN_MSBS = 6'd46,
    FN_MSBU = 6'd47
  } mduFunc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOps;
    logic divIter;
    logic divFix;
    logic mulCommit;
    logic writeHi;
    logic writeLo;
    logic readHi;
    logic readLo;
  } mduStrobes_t;

endpackage

// File: rtl/mdu_div_step.sv
module mdu_div_step #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] remIn,
  input  logic [DATA_W-1:0] quoIn,
  input  logic [DATA_W-1:0] divisor,
  output logic [DATA_W-1:0] remOut,
  output logic [DATA_W-1:0] quoOut
);
  logic [DATA_W:0] shifted;
  logic [DATA_W:0] diff;
  logic            qBit;

  always_comb begin
    shifted = {remIn, quoIn[DATA_W-1]};
    diff    = shifted - {1'b0, divisor};
    qBit    = ~diff[DATA_W];
    remOut  = qBit ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
    quoOut  = {quoIn[DATA_W-2:0], qBit};
  end
endmodule

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MUL_LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  func,
  output mduStrobes_t strb,
  output logic        busy,
  output logic        done
);
  localparam int MAX_CNT = (DATA_W > MUL_LAT) ? DATA_W : MUL_LAT;
  localparam int CNT_W   = $clog2(MAX_CNT) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_DIV, ST_FIX} state_e;

  state_e           state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             doneNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    cntNext   = cnt;
    doneNext  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          case (func)
            FN_MFHI: begin strb.readHi  = 1'b1; doneNext = 1'b1; end
            FN_MFLO: begin strb.readLo  = 1'b1; doneNext = 1'b1; end
            FN_MTHI: begin strb.writeHi = 1'b1; doneNext = 1'b1; end
            FN_MTLO: begin strb.writeLo = 1'b1; doneNext = 1'b1; end
            FN_MULS, FN_MULU, FN_MACS, FN_MACU, FN_MSBS, FN_MSBU: begin
              strb.loadOps = 1'b1;
              stateNext    = ST_MUL;
              cntNext      = CNT_W'(MUL_LAT - 1);
            end
            FN_DIVS, FN_DIVU: begin
              strb.loadOps = 1'b1;
              stateNext    = ST_DIV;
              cntNext      = CNT_W'(DATA_W - 1);
            end
            default: ;
          endcase
        end
      end
      ST_MUL: begin
        if (cnt == '0) begin
          strb.mulCommit = 1'b1;
          doneNext       = 1'b1;
          stateNext      = ST_IDLE;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_DIV: begin
        strb.divIter = 1'b1;
        if (cnt == '0) stateNext = ST_FIX;
        else           cntNext   = cnt - 1'b1;
      end
      default: begin
        strb.divFix = 1'b1;
        doneNext    = 1'b1;
        stateNext   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      done  <= doneNext;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  mduStrobes_t          strb,
  input  logic [5:0]           func,
  input  logic [DATA_W-1:0]    rsVal,
  input  logic [DATA_W-1:0]    rtVal,
  input  logic [REG_IDX_W-1:0] rdIdx,
  output logic [DATA_W-1:0]    hiOut,
  output logic [DATA_W-1:0]    loOut,
  output logic [DATA_W-1:0]    moveData,
  output logic                 moveWe
);
  localparam int DW2 = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ALL_ONES  = '1;
  localparam logic [DATA_W-1:0] SMALL_LIM = {{(DATA_W - DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG   = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] hiReg, loReg, opA, opB;
  logic [5:0]        fnReg;
  logic [DATA_W-1:0] remReg, quoReg, dvsMag;
  logic [DATA_W-1:0] remStep, quoStep;

  // ---------------- multiply path ----------------
  logic                  mulSigned;
  logic signed [DW2-1:0] extA, extB;
  logic        [DW2-1:0] product, accNext;

  always_comb begin
    mulSigned = (fnReg == FN_MULS) || (fnReg == FN_MACS) || (fnReg == FN_MSBS);
    extA      = {{DATA_W{mulSigned & opA[DATA_W-1]}}, opA};
    extB      = {{DATA_W{mulSigned & opB[DATA_W-1]}}, opB};
    product   = extA * extB;
    case (fnReg)
      FN_MACS, FN_MACU: accNext = {hiReg, loReg} + product;
      FN_MSBS, FN_MSBU: accNext = {hiReg, loReg} - product;
      default:          accNext = product;
    endcase
  end

  // ---------------- divide path ----------------
  logic              inSigned, inNegA, inNegB;
  logic [DATA_W-1:0] inMagA, inMagB;

  always_comb begin
    inSigned = (func == FN_DIVS);
    inNegA   = inSigned & rsVal[DATA_W-1];
    inNegB   = inSigned & rtVal[DATA_W-1];
    inMagA   = inNegA ? (~rsVal + ONE) : rsVal;
    inMagB   = inNegB ? (~rtVal + ONE) : rtVal;
  end

  mdu_div_step #(.DATA_W(DATA_W)) i_divStep (
    .remIn   (remReg),
    .quoIn   (quoReg),
    .divisor (dvsMag),
    .remOut  (remStep),
    .quoOut  (quoStep)
  );

  logic              divSigned, negA, negB, divZero, divOvf;
  logic [DATA_W-1:0] fixHi, fixLo;

  always_comb begin
    divSigned = (fnReg == FN_DIVS);
    negA      = divSigned & opA[DATA_W-1];
    negB      = divSigned & opB[DATA_W-1];
    divZero   = (opB == '0);
    divOvf    = divSigned && (opA == MIN_NEG) && (opB == ALL_ONES);
    if (divZero) begin
      fixHi = opA;
      if (divSigned) fixLo = opA[DATA_W-1] ? ONE : ALL_ONES;
      else           fixLo = (opA > SMALL_LIM) ? ALL_ONES : SMALL_LIM;
    end else if (divOvf) begin
      fixHi = ALL_ONES;
      fixLo = MIN_NEG;
    end else begin
      fixLo = (negA ^ negB) ? (~quoReg + ONE) : quoReg;
      fixHi = negA ? (~remReg + ONE) : remReg;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hiReg    <= '0;
      loReg    <= '0;
      opA      <= '0;
      opB      <= '0;
      fnReg    <= '0;
      remReg   <= '0;
      quoReg   <= '0;
      dvsMag   <= '0;
      moveData <= '0;
      moveWe   <= 1'b0;
    end else begin
      moveWe <= (strb.readHi | strb.readLo) && (rdIdx != '0);
      if (strb.readHi) moveData <= hiReg;
      if (strb.readLo) moveData <= loReg;
      if (strb.writeHi) hiReg <= rsVal;
      if (strb.writeLo) loReg <= rsVal;
      if (strb.loadOps) begin
        opA    <= rsVal;
        opB    <= rtVal;
        fnReg  <= func;
        remReg <= '0;
        quoReg <= inMagA;
        dvsMag <= inMagB;
      end
      if (strb.divIter) begin
        remReg <= remStep;
        quoReg <= quoStep;
      end
      if (strb.mulCommit) {hiReg, loReg} <= accNext;
      if (strb.divFix) begin
        hiReg <= fixHi;
        loReg <= fixLo;
      end
    end
  end

  assign hiOut = hiReg;
  assign loOut = loReg;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MUL_LAT   = 2,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [5:0]           func,
  input  logic [DATA_W-1:0]    rsVal,
  input  logic [DATA_W-1:0]    rtVal,
  input  logic [REG_IDX_W-1:0] rdIdx,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_W-1:0]    hiOut,
  output logic [DATA_W-1:0]    loOut,
  output logic [DATA_W-1:0]    moveData,
  output logic                 moveWe
);
  mduStrobes_t strb;

  mdu_ctrl #(.DATA_W(DATA_W), .MUL_LAT(MUL_LAT)) i_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .func  (func),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  mdu_datapath #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .func     (func),
    .rsVal    (rsVal),
    .rtVal    (rtVal),
    .rdIdx    (rdIdx),
    .hiOut    (hiOut),
    .loOut    (loOut),
    .moveData (moveData),
    .moveWe   (moveWe)
  );
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker
  import mdu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [5:0]           func,
  input logic [DATA_W-1:0]    rsVal,
  input logic [REG_IDX_W-1:0] rdIdx,
  input logic                 busy,
  input logic                 done,
  input logic [DATA_W-1:0]    hiOut,
  input logic [DATA_W-1:0]    loOut,
  input logic [DATA_W-1:0]    moveData,
  input logic                 moveWe
);
  logic accept;
  assign accept = start && !busy;

  // R10: completion pulse is only seen with the unit idle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: read aimed at index zero never raises the write enable
  p_zero_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (func == FN_MFHI || func == FN_MFLO) && rdIdx == '0) |=> !moveWe);

  // R8: read of HI returns the value HI held when accepted
  p_read_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && func == FN_MFHI) |=> (moveData == $past(hiOut)));

  // R8: write of LO takes the operand
  p_write_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && func == FN_MTLO) |=> (loOut == $past(rsVal)));

  // R11: with no request and nothing in flight, the pair holds
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hiOut) && $stable(loOut)));

  // R11: a request while busy does not end the unit's busy period early
  p_busy_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind muldiv_unit mdu_checker #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) i_mdu_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .func     (func),
  .rsVal    (rsVal),
  .rdIdx    (rdIdx),
  .busy     (busy),
  .done     (done),
  .hiOut    (hiOut),
  .loOut    (loOut),
  .moveData (moveData),
  .moveWe   (moveWe)
);

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;
  localparam int W       = 32;
  localparam int MUL_LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  func = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [4:0]  rdIdx = '0;
  logic        busy, done, moveWe;
  logic [31:0] hiOut, loOut, moveData;

  int total = 0;
  int bad = 0;
  logic [31:0] mHi = '0;
  logic [31:0] mLo = '0;

  always #4 clk = ~clk;

  muldiv_unit #(.DATA_W(W), .MUL_LAT(MUL_LAT), .REG_IDX_W(5)) i_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .func(func), .rsVal(rsVal),
    .rtVal(rtVal), .rdIdx(rdIdx), .busy(busy), .done(done), .hiOut(hiOut),
    .loOut(loOut), .moveData(moveData), .moveWe(moveWe)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] refOp(input logic [5:0] f, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] h,
                                        input logic [31:0] l);
    logic [63:0] p;
    int sa, sb;
    if (f == 24 || f == 28 || f == 46)
      p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    else
      p = {32'b0, a} * {32'b0, b};
    case (f)
      24, 25: return p;
      28, 29: return {h, l} + p;
      46, 47: return {h, l} - p;
      26: begin
        if (b == 0) return {a, (a[31] ? 32'd1 : 32'hFFFFFFFF)};
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return {32'hFFFFFFFF, 32'h80000000};
        sa = a; sb = b;
        return {32'(sa % sb), 32'(sa / sb)};
      end
      27: begin
        if (b == 0) return {a, ((a > 32'h0000FFFF) ? 32'hFFFFFFFF : 32'h0000FFFF)};
        return {a % b, a / b};
      end
      default: return {h, l};
    endcase
  endfunction

  function automatic string reqTag(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      24, 25: return "R1";
      28, 29: return "R2";
      46, 47: return "R3";
      26: begin
        if (b == 0) return "R5";
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return "R7";
        return "R4";
      end
      27: return (b == 0) ? "R6" : "R4";
      default: return "R8";
    endcase
  endfunction

  // Called at a negedge; returns at the negedge where done is seen.
  task automatic runOp(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] rd);
    int k;
    int expLat;
    logic [63:0] res;
    string tag;
    tag = reqTag(f, a, b);
    func = f; rsVal = a; rtVal = b; rdIdx = rd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    if (f >= 24) check("R10 busy after accept", {63'b0, busy}, 64'd1);
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    if (f >= 26 && f <= 27) expLat = W + 2;
    else if (f >= 24)       expLat = MUL_LAT + 1;
    else                    expLat = 1;
    check("R10 latency", 64'(k), 64'(expLat));
    check("R10 busy low at done", {63'b0, busy}, 64'd0);
    case (f)
      16: begin
        check("R8 read HI", {32'b0, moveData}, {32'b0, mHi});
        check("R9 write enable", {63'b0, moveWe}, {63'b0, (rd != 0)});
      end
      18: begin
        check("R8 read LO", {32'b0, moveData}, {32'b0, mLo});
        check("R9 write enable", {63'b0, moveWe}, {63'b0, (rd != 0)});
      end
      17: mHi = a;
      19: mLo = a;
      default: begin
        res = refOp(f, a, b, mHi, mLo);
        mHi = res[63:32];
        mLo = res[31:0];
      end
    endcase
    check({tag, " HI:LO"}, {hiOut, loOut}, {mHi, mLo});
  endtask

  function automatic logic [31:0] pickOperand();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'h80000000;
      2: return 32'hFFFFFFFF;
      3: return $urandom % 32'h20000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R10 act=timeout exp=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] fnList [12];
    logic [63:0] res;
    int k;
    fnList = '{6'd16, 6'd17, 6'd18, 6'd19, 6'd24, 6'd25, 6'd26, 6'd27, 6'd28, 6'd29, 6'd46, 6'd47};
    void'($urandom(32'd7731));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 reset HI:LO", {hiOut, loOut}, 64'd0);
    check("R12 reset busy/done/we", {61'b0, busy, done, moveWe}, 64'd0);

    // R8 / R9 moves
    runOp(17, 32'h12345678, 0, 0);
    runOp(19, 32'h9ABCDEF0, 0, 0);
    runOp(16, 0, 0, 5'd5);
    runOp(18, 0, 0, 5'd0);
    runOp(16, 0, 0, 5'd0);

    // R1 multiplies
    runOp(24, 32'hFFFFFFFD, 32'd7, 1);
    runOp(25, 32'hFFFFFFFF, 32'hFFFFFFFF, 1);
    runOp(24, 32'h80000000, 32'h80000000, 1);
    // R2 carry from LO into HI
    runOp(19, 32'hFFFFFFFF, 0, 0);
    runOp(17, 32'h0, 0, 0);
    runOp(29, 32'd1, 32'd1, 1);
    check("R2 carry directed", {hiOut, loOut}, 64'h00000001_00000000);
    runOp(28, 32'hFFFFFFFF, 32'd3, 1);
    // R3 borrow from HI
    runOp(19, 32'h0, 0, 0);
    runOp(17, 32'd5, 0, 0);
    runOp(47, 32'd1, 32'd1, 1);
    check("R3 borrow directed", {hiOut, loOut}, 64'h00000004_FFFFFFFF);
    runOp(46, 32'hFFFFFFFE, 32'd3, 1);

    // R4 divides
    runOp(26, 32'hFFFFFFF9, 32'd2, 1);
    check("R4 -7/2", {hiOut, loOut}, {32'hFFFFFFFF, 32'hFFFFFFFD});
    runOp(26, 32'd7, 32'hFFFFFFFE, 1);
    runOp(27, 32'd100, 32'd7, 1);
    runOp(27, 32'hFFFFFFFF, 32'd1, 1);
    // R5 signed divide by zero
    runOp(26, 32'd9, 32'd0, 1);
    runOp(26, 32'hFFFFFF00, 32'd0, 1);
    // R6 unsigned divide by zero
    runOp(27, 32'h00010000, 32'd0, 1);
    runOp(27, 32'h0000FFFF, 32'd0, 1);
    runOp(27, 32'h0, 32'd0, 1);
    // R7 overflow
    runOp(26, 32'h80000000, 32'hFFFFFFFF, 1);

    // R11 start while busy: move to HI issued in the middle of a divide
    func = 6'd26; rsVal = 32'd1000; rtVal = 32'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    func = 6'd17; rsVal = 32'hDEADBEEF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 3;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    res = refOp(6'd26, 32'd1000, 32'd7, mHi, mLo);
    mHi = res[63:32]; mLo = res[31:0];
    check("R11 busy start ignored latency", 64'(k), 64'(W + 2));
    check("R11 busy start ignored HI:LO", {hiOut, loOut}, {mHi, mLo});

    // R11 unknown code ignored
    func = 6'd20; rsVal = 32'h55555555; rtVal = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R11 unknown code no done", {62'b0, done, busy}, 64'd0);
      @(negedge clk);
    end
    check("R11 unknown code HI:LO kept", {hiOut, loOut}, {mHi, mLo});

    // random stream, back-to-back issue on the done cycle
    for (int n = 0; n < 400; n++) begin
      runOp(fnList[$urandom % 12], pickOperand(), pickOperand(), 5'($urandom % 4));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule